// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a synchronous host read and write an external 8K x 8 asynchronous static RAM. The RAM has two chip selects of opposite polarity, an output enable, a write enable and one bidirectional data bus. The controller splits that bus into an output word, a driver enable and an input word, so that the pad ring can build the tri-state buffer. Every timing window is a clock-cycle count set by a parameter, so the same RTL fits any clock rate once the counts are worked out from the RAM's nanosecond limits.

The host side is a valid/ready request channel followed by a one-cycle response pulse. A request carries an address, a direction flag and a write byte. The host holds `req_valid` and the request fields stable until it sees `req_ready` high at a clock edge. The transfer happens on that edge, and the controller then keeps `req_ready` low until the access is over. The response channel has no back-pressure: `rsp_valid` is high for exactly one cycle, and `rsp_rdata` keeps the last read byte until the next read finishes.

A read selects the device, lowers the output enable for `RD_CYC` cycles and registers the bus on the edge that ends that window. A write first presents the address with the device selected. It waits until the bus turn-around window has passed since the output enable last went high. It then holds the write strobe low and drives the data for max(`WE_CYC`, `SU_CYC`) cycles. Between any two accesses there is at least one cycle with the device deselected.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever idle: `req_ready`=1, `ram_ce1_n`=1, `ram_ce2`=0, `ram_oe_n`=1, `ram_we_n`=1, `ram_dq_oe`=0 and `rsp_valid`=0.
- R2: A request is taken only on an edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge until the access's response cycle, and request fields that change while busy have no effect on the access in flight.
- R3: A read (`req_write`=0) holds `ram_ce1_n`=0, `ram_ce2`=1, `ram_oe_n`=0 and `ram_we_n`=1 for `RD_CYC` cycles. It registers `ram_dq_in` on the edge that ends that window, and presents the byte on `rsp_rdata` with `rsp_valid` in the next cycle. With defaults, `rsp_valid` appears in the 5th cycle after the accepting edge.
- R4: A write (`req_write`=1) keeps the device selected and `ram_oe_n`=1 throughout. It holds `ram_we_n`=0 for exactly max(`WE_CYC`, `SU_CYC`) cycles (3 with defaults). From an idle bus, `rsp_valid` appears in the 5th cycle after the accepting edge.
- R5: `ram_dq_oe` is 1 only while `ram_we_n`=0, and `ram_dq_out` is stable for the whole strobe (at least `SU_CYC` cycles before the strobe rises).
- R6: The address is presented with the device selected for at least one cycle before the write strobe falls.
- R7: `ram_dq_oe` is never 1 within `TA_CYC` cycles of `ram_oe_n` rising, so a write that directly follows a read takes one extra cycle (response in the 6th cycle with defaults).
- R8: `ram_oe_n` and `ram_we_n` are never both 0, and `ram_dq_oe`=1 never coincides with `ram_oe_n`=0.
- R9: `rsp_valid` is a single-cycle pulse, one per accepted request.
- R10: In the response cycle the device is deselected (`ram_ce1_n`=1, `ram_ce2`=0) with both strobes high, so accesses are separated by at least one idle cycle.
- R11: All 13 address bits reach `ram_addr` and stay stable while the device is selected. Data written to the lowest (0x0000) and highest (0x1FFF) addresses reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last byte read |
| ram_addr | output | 13 | RAM address pins |
| ram_ce1_n | output | 1 | Active-low chip select |
| ram_ce2 | output | 1 | Active-high chip select |
| ram_oe_n | output | 1 | Active-low output enable |
| ram_we_n | output | 1 | Active-low write strobe |
| ram_dq_out | output | 8 | Byte driven onto the data bus |
| ram_dq_oe | output | 1 | Bus driver enable |
| ram_dq_in | input | 8 | Byte sampled from the data bus |

## Verification
The hardest case to reach is a write that is accepted while the RAM may still be driving the bus after a read. This happens only when the host issues the write in the very response cycle of a read. The bench reaches it by issuing requests back to back from inside its access task, and it measures the write's extra cycle of latency. A cycle-level RAM model drives junk on the bus until the access and output-enable windows have elapsed, so a shortened read returns wrong data. The model also flags any driver enable that falls inside its release window.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_READ   = 2'd1,
    ST_WADDR  = 2'd2,
    ST_WPULSE = 2'd3
  } ctrl_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_ctrl_turn.sv
// Counts cycles since the output enable last rose; saturates at TA_CYC.
module sram_ctrl_turn #(
  parameter int TA_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_n,
  output logic ta_ok
);
  localparam int TW = $clog2(TA_CYC + 1);
  localparam logic [TW-1:0] TA_MAX = TW'(TA_CYC);

  logic [TW-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              gap_cnt <= TA_MAX;
    else if (!oe_n)          gap_cnt <= '0;
    else if (gap_cnt != TA_MAX) gap_cnt <= gap_cnt + 1'b1;
  end

  assign ta_ok = (gap_cnt == TA_MAX);

  // R7: a cycle with the output enable low always closes the window
  p_turn_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |=> !ta_ok);
endmodule

// File: rtl/sram_ctrl_seq.sv
// Access sequencer: idle, read window, write address phase, write strobe.
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC = 4,
  parameter int WE_CYC = 3,
  parameter int SU_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        ta_ok,
  output ctrl_state_e st,
  output logic        accept,
  output logic        rd_end,
  output logic        wr_end
);
  localparam int PULSE   = int'(max_u(WE_CYC, SU_CYC));
  localparam int LONGEST = int'(max_u(RD_CYC, PULSE));
  localparam int CW      = $clog2(LONGEST + 1);
  localparam logic [CW-1:0] RD_LAST = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WE_LAST = CW'(PULSE - 1);

  ctrl_state_e   st_nx;
  logic [CW-1:0] cnt, cnt_nx;

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    accept = 1'b0;
    rd_end = 1'b0;
    wr_end = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          cnt_nx = '0;
          st_nx  = req_write ? ST_WADDR : ST_READ;
        end
      end
      ST_READ: begin
        if (cnt == RD_LAST) begin
          rd_end = 1'b1;
          st_nx  = ST_IDLE;
        end else begin
          cnt_nx = cnt + 1'b1;
        end
      end
      ST_WADDR: begin
        if (ta_ok) begin
          cnt_nx = '0;
          st_nx  = ST_WPULSE;
        end
      end
      ST_WPULSE: begin
        if (cnt == WE_LAST) begin
          wr_end = 1'b1;
          st_nx  = ST_IDLE;
        end else begin
          cnt_nx = cnt + 1'b1;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_nx;
      cnt <= cnt_nx;
    end
  end

  // R6: the write strobe phase is entered only from the address phase
  p_pulse_after_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WPULSE && $past(st) != ST_WPULSE) |-> $past(st) == ST_WADDR);
  // R10: every access begins from idle
  p_start_from_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READ && $past(st) != ST_READ) |-> $past(st) == ST_IDLE);
endmodule

// File: rtl/sram_ctrl_dpath.sv
// Request capture, read capture and response pulse.
module sram_ctrl_dpath #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          rd_end,
  input  logic          wr_end,
  input  logic [DW-1:0] bus_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q,
  output logic          ack
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      ack     <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (rd_end) rdata_q <= bus_in;
      ack <= rd_end | wr_end;
    end
  end

  // R3: the read byte is held between read completions
  p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_end |=> $stable(rdata_q));
  // R2: request fields are captured only at acceptance
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(addr_q));
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW     = 13,
  parameter int DW     = 8,
  parameter int RD_CYC = 4,
  parameter int WE_CYC = 3,
  parameter int SU_CYC = 2,
  parameter int TA_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] ram_addr,
  output logic          ram_ce1_n,
  output logic          ram_ce2,
  output logic          ram_oe_n,
  output logic          ram_we_n,
  output logic [DW-1:0] ram_dq_out,
  output logic          ram_dq_oe,
  input  logic [DW-1:0] ram_dq_in
);
  ctrl_state_e st;
  logic accept, rd_end, wr_end, ta_ok;

  sram_ctrl_turn #(.TA_CYC(TA_CYC)) u_turn (
    .clk(clk), .rst_n(rst_n), .oe_n(ram_oe_n), .ta_ok(ta_ok)
  );

  sram_ctrl_seq #(.RD_CYC(RD_CYC), .WE_CYC(WE_CYC), .SU_CYC(SU_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .ta_ok(ta_ok), .st(st), .accept(accept), .rd_end(rd_end), .wr_end(wr_end)
  );

  sram_ctrl_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_end(rd_end), .wr_end(wr_end), .bus_in(ram_dq_in),
    .addr_q(ram_addr), .wdata_q(ram_dq_out), .rdata_q(rsp_rdata), .ack(rsp_valid)
  );

  // Strobes decoded from the registered state
  assign req_ready = (st == ST_IDLE);
  assign ram_ce1_n = (st == ST_IDLE);
  assign ram_ce2   = (st != ST_IDLE);
  assign ram_oe_n  = (st != ST_READ);
  assign ram_we_n  = (st != ST_WPULSE);
  assign ram_dq_oe = (st == ST_WPULSE);

  // R8: strobes never both active
  p_oe_we_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(~ram_oe_n && ~ram_we_n));
  // R8: no drive while the RAM may be driving
  p_drive_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe |-> ram_oe_n);
  // R5: write byte stable across the strobe
  p_data_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_we_n && $past(!ram_we_n)) |-> $stable(ram_dq_out));
  // R11: address stable while selected
  p_addr_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_ce1_n && $past(!ram_ce1_n)) |-> $stable(ram_addr));
  // R9: single-cycle response
  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R10: response cycle is a deselected idle cycle
  p_idle_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (ram_ce1_n && !ram_ce2 && ram_we_n && ram_oe_n));
  // R2: acceptance closes the ready window
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb;
  localparam int TCLK = 20;
  // RAM limits in cycles of a 20 ns clock
  localparam int M_ACC = 4;  // address to data, 80 ns
  localparam int M_OE  = 2;  // OE low to data, 40 ns
  localparam int M_WP  = 3;  // write strobe width, 60 ns
  localparam int M_DS  = 2;  // data setup, 40 ns
  localparam int M_AW  = 4;  // address valid to end of write, 70 ns
  localparam int M_REL = 2;  // release after OE rises, 30 ns turn-around

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, ram_ce1_n, ram_ce2, ram_oe_n, ram_we_n, ram_dq_oe;
  logic [7:0] rsp_rdata, ram_dq_out;
  logic [12:0] ram_addr;
  logic [7:0] ram_rd = 8'hEE;

  int checks = 0, errors = 0, cyc = 0;

  always #(TCLK/2) clk = ~clk;

  sram_async_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ram_addr(ram_addr),
    .ram_ce1_n(ram_ce1_n), .ram_ce2(ram_ce2), .ram_oe_n(ram_oe_n),
    .ram_we_n(ram_we_n), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe),
    .ram_dq_in(ram_rd)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      check("watchdog", "run length", cyc, 0);
      finish_run();
    end
  end

  // ---------------- cycle-level RAM model ----------------
  logic [7:0] mem [logic [12:0]];
  int we_run = 0, su_run = 0, addr_run = 0, oe_run = 0, hi_run = 99, cap_arun = 0;
  logic [7:0] cap_d, prev_dq;
  logic [12:0] cap_a, prev_a;
  logic prev_sel = 1'b0, prev_we_n = 1'b1, prev_oe_dq = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      automatic logic sel = !ram_ce1_n && ram_ce2;
      if (!ram_oe_n && !ram_we_n) check("R8", "OE and WE both low", 1, 0);
      if (ram_dq_oe && !ram_oe_n) check("R8", "bus contention", 1, 0);
      if (ram_dq_oe && hi_run < M_REL) check("R7", "drive inside release window", hi_run, M_REL);
      if (ram_dq_oe && ram_we_n) check("R5", "drive without strobe", 1, 0);
      if (sel && prev_sel && ram_addr != prev_a) check("R11", "address moved while selected", ram_addr, prev_a);
      hi_run = ram_oe_n ? ((hi_run < 99) ? hi_run + 1 : hi_run) : 0;
      addr_run = !sel ? 0 : ((prev_sel && ram_addr == prev_a) ? addr_run + 1 : 1);
      if (!ram_we_n) begin
        if (!sel) check("R4", "strobe while deselected", 1, 0);
        we_run++;
        su_run = !ram_dq_oe ? 0 : ((prev_oe_dq && ram_dq_out == prev_dq) ? su_run + 1 : 1);
        cap_d = ram_dq_out; cap_a = ram_addr; cap_arun = addr_run;
      end else if (!prev_we_n) begin
        if (we_run < M_WP) check("R4", "strobe width", we_run, M_WP);
        if (su_run < M_DS) check("R5", "data setup", su_run, M_DS);
        if (cap_arun < M_AW) check("R6", "address to end of write", cap_arun, M_AW);
        mem[cap_a] = cap_d;
        we_run = 0;
      end
      if (sel && !ram_oe_n && ram_we_n) begin
        oe_run++;
        ram_rd = (oe_run >= M_OE && addr_run >= M_ACC)
                 ? (mem.exists(ram_addr) ? mem[ram_addr] : 8'h00) : 8'hEE;
      end else begin
        oe_run = 0;
        ram_rd = 8'hEE;
      end
      prev_sel = sel; prev_a = ram_addr; prev_we_n = ram_we_n;
      prev_oe_dq = ram_dq_oe; prev_dq = ram_dq_out;
    end
  end

  // ---------------- host access task (called at a falling edge) ----------------
  task automatic do_op(input logic wr, input logic [12:0] a, input logic [7:0] d,
                       output logic [7:0] rd, output int lat);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check("R10", "deselected in response cycle",
          {ram_ce1_n, ram_ce2, ram_oe_n, ram_we_n}, 4'b1011);
    rd = rsp_rdata;
  endtask

  // {write, address, data or expected byte}
  localparam logic [21:0] VEC [10] = '{
    {1'b1, 13'h0000, 8'hA5}, {1'b1, 13'h1FFF, 8'h5A},
    {1'b0, 13'h0000, 8'hA5}, {1'b0, 13'h1FFF, 8'h5A},
    {1'b1, 13'h0ABC, 8'h3C}, {1'b0, 13'h0ABC, 8'h3C},
    {1'b1, 13'h0ABC, 8'hC3}, {1'b0, 13'h0ABC, 8'hC3},
    {1'b1, 13'h1555, 8'hFF}, {1'b0, 13'h1555, 8'hFF}
  };

  initial begin
    logic [7:0] rd;
    int lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", "idle pins {ready,ce1_n,ce2,oe_n,we_n,dq_oe,rsp}",
          {req_ready, ram_ce1_n, ram_ce2, ram_oe_n, ram_we_n, ram_dq_oe, rsp_valid},
          7'b1101100);

    // Vector table walk
    for (int i = 0; i < 10; i++) begin
      do_op(VEC[i][21], VEC[i][20:8], VEC[i][7:0], rd, lat);
      if (!VEC[i][21]) begin
        check("R3", $sformatf("read data vec %0d", i), rd, VEC[i][7:0]);
        check("R3", $sformatf("read latency vec %0d", i), lat, 5);
        check("R11", "range endpoint read", rd, VEC[i][7:0]);
      end
    end

    // R7: write immediately after a read waits for bus release
    do_op(1'b0, 13'h0000, 8'h00, rd, lat);
    do_op(1'b1, 13'h0042, 8'h81, rd, lat);
    check("R7", "write after read latency", lat, 6);
    // R4: write from an idle bus
    do_op(1'b1, 13'h0043, 8'h7E, rd, lat);
    check("R4", "write after write latency", lat, 5);
    // R9: response lasts one cycle
    @(negedge clk);
    check("R9", "response pulse width", rsp_valid, 0);
    check("R1", "idle after access", {req_ready, ram_ce1_n, ram_dq_oe}, 3'b110);

    // R2: fields changed while busy are ignored; ready low while busy
    req_valid = 1'b1; req_write = 1'b0; req_addr = 13'h0042;
    @(negedge clk);
    req_addr = 13'h0043; req_write = 1'b1; req_wdata = 8'h00;
    check("R2", "ready while busy", req_ready, 0);
    lat = 1;
    while (!rsp_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    req_valid = 1'b0;
    check("R2", "read used accepted address", rsp_rdata, 8'h81);
    @(negedge clk);
    do_op(1'b0, 13'h0043, 8'h00, rd, lat);
    check("R2", "busy-time write data had no effect", rd, 8'h7E);
    do_op(1'b0, 13'h0042, 8'h00, rd, lat);
    check("R5", "readback of write after read", rd, 8'h81);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule